// File: doc/BRIEF.md
# Debounced GPIO Port Controller

A 32-pin general-purpose I/O port that software reaches through a small register bus of 32-bit word reads and writes. Each pin can be an input or an output. Outputs can drive push-pull or open-drain, and the block produces registered output-enable and output-value signals for the pads.

Raw pad inputs pass through a two-flop synchronizer. Each pin then has its own optional debounce filter. The filter's stable-time threshold is counted in ticks from a shared prescaler that pulses once every `TICK_DIV` system clocks, which is 50 µs at the intended clock rate. A pin's filter only moves its output to a new level after the synchronized input has held that level for the programmed number of ticks. Software reads the resulting levels from a status register.

Top module: `dbgpio_port`

## Requirements
- R1: After synchronous reset, the direction, output-data, filter-enable, open-drain and all threshold registers read zero, and `pad_oe` is all zeros.
- R2: Words at byte offsets 0x00 (direction, 1 = output), 0x0C (output data), 0x18 (filter enable) and 0x1C (open-drain select) read back what was last written to them. `bus_rdata` is registered and valid in the cycle after `bus_rd`.
- R3: Pin n's threshold register sits at byte offset 0x80 + 4·n. Only bits 15:0 are stored, and bits 31:16 read as zero.
- R4: When a pin's open-drain bit is 0 (push-pull), `pad_oe` equals its direction bit and `pad_out` equals its data bit. Pad outputs are registered and follow a register write by one cycle.
- R5: When a pin's open-drain bit is 1, `pad_out` is 0 and `pad_oe` is asserted only when the direction bit is 1 and the data bit is 0.
- R6: Offset 0x04 returns the per-pin input level after synchronizing and optional filtering. Writes to 0x04 have no effect.
- R7: When a pin's filter-enable bit (bit n of 0x18) is 0, its status follows the pad input after the two-flop synchronizer plus one register stage.
- R8: When the filter-enable bit is 1 with threshold T, the status changes only on the T-th prescaler tick counted while the synchronized input differs from the current status. The prescaler pulses for one cycle every `TICK_DIV` clocks, and a threshold of 0 acts like 1.
- R9: If the synchronized input returns to the current status before the threshold is reached, the tick count restarts from zero.
- R10: Reads from unmapped or non-word-aligned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad input levels |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |

## Verification
The bench holds a pad at its new level for fewer ticks than the threshold and confirms the status has not moved; a filter that compared against the wrong count, or that ignored the enable bit, would switch early. It then produces a bounce whose two high windows together exceed the threshold but neither does alone. A filter that kept its count across the bounce would flip the status, while a correct one keeps the old level. Open-drain pins are driven with data 1, where a design that drove high instead of releasing would show `pad_oe` set. Misaligned and unmapped accesses are issued, and an incomplete decode would corrupt the direction or open-drain words.

// File: rtl/dbgpio_pkg.sv
package dbgpio_pkg;
  // word indices (byte offset / 4) of the register map
  localparam int WI_DIR  = 0;
  localparam int WI_STAT = 1;
  localparam int WI_DATA = 3;
  localparam int WI_DBEN = 6;
  localparam int WI_OD   = 7;
  localparam int WI_THR0 = 32;
endpackage

// File: rtl/dbgpio_tick.sv
module dbgpio_tick #(
  parameter int TICK_DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick  <= (cnt_q == LAST);
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst || TICK_DIV < 2)
    tick |=> !tick); // R8
endmodule

// File: rtl/dbgpio_sync.sv
module dbgpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dbgpio_filter.sv
module dbgpio_filter #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic             sin,
  output logic             lvl
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      lvl   <= sin;
    end else if (sin == lvl) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, thr}) begin
        cnt_q <= '0;
        lvl   <= sin;
      end else begin
        cnt_q <= cnt_inc[THR_W-1:0];
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(lvl)); // R8
  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (rst)
    (en && sin == lvl) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/dbgpio_port.sv
module dbgpio_port #(
  parameter int PINS     = 32,
  parameter int THR_W    = 16,
  parameter int TICK_DIV = 5000,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out
);
  import dbgpio_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int PIN_W  = (PINS > 1) ? $clog2(PINS) : 1;

  logic [PINS-1:0]  dir_q, data_q, dben_q, od_q;
  logic [THR_W-1:0] thr_q [PINS];
  logic [PINS-1:0]  sync_in, level;
  logic             tick;

  logic [WORD_W-1:0] word;
  logic              aligned, thr_hit;
  logic [PIN_W-1:0]  tidx;
  logic [DATA_W-1:0] rd_next;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign thr_hit = aligned && (int'(word) >= WI_THR0) && (int'(word) < WI_THR0 + PINS);
  assign tidx    = PIN_W'(int'(word) - WI_THR0);

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      dben_q <= '0;
      od_q   <= '0;
      for (int i = 0; i < PINS; i++) thr_q[i] <= '0;
    end else if (bus_wr) begin
      if (aligned) begin
        case (int'(word))
          WI_DIR:  dir_q  <= bus_wdata[PINS-1:0];
          WI_DATA: data_q <= bus_wdata[PINS-1:0];
          WI_DBEN: dben_q <= bus_wdata[PINS-1:0];
          WI_OD:   od_q   <= bus_wdata[PINS-1:0];
          default: ;
        endcase
      end
      for (int i = 0; i < PINS; i++)
        if (thr_hit && tidx == PIN_W'(i)) thr_q[i] <= bus_wdata[THR_W-1:0];
    end
  end

  // read mux
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      case (int'(word))
        WI_DIR:  rd_next = DATA_W'(dir_q);
        WI_STAT: rd_next = DATA_W'(level);
        WI_DATA: rd_next = DATA_W'(data_q);
        WI_DBEN: rd_next = DATA_W'(dben_q);
        WI_OD:   rd_next = DATA_W'(od_q);
        default: rd_next = '0;
      endcase
      if (thr_hit) rd_next = DATA_W'(thr_q[tidx]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // pad drive: open-drain only ever pulls low
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= dir_q & ~(od_q & data_q);
      pad_out <= data_q & ~od_q;
    end
  end

  dbgpio_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  dbgpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_in)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    dbgpio_filter #(.THR_W(THR_W)) u_filt (
      .clk (clk),
      .rst (rst),
      .tick(tick),
      .en  (dben_q[g]),
      .thr (thr_q[g]),
      .sin (sync_in[g]),
      .lvl (level[g])
    );
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & pad_out & $past(od_q)) == '0)); // R5
  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(dir_q)) == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !aligned) |=> (bus_rdata == '0)); // R10
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && aligned && int'(word) == WI_STATE_GUARD) |=> $stable(dir_q)); // R6
  localparam int WI_STATE_GUARD = WI_STAT;
endmodule

// File: tb/sim_dbgpio_port.sv
module sim_dbgpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 8;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgpio_port #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 dir", v, 32'h0);
    rd(8'h0C, v); chk("R1 data", v, 32'h0);
    rd(8'h18, v); chk("R1 dben", v, 32'h0);
    rd(8'h1C, v); chk("R1 od", v, 32'h0);
    rd(8'h80, v); chk("R1 thr0", v, 32'h0);
    rd(8'hFC, v); chk("R1 thr31", v, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, v); chk("R2 dir", v, 32'hA5A5_0F0F);
    wr(8'h0C, 32'h1234_ABCD); rd(8'h0C, v); chk("R2 data", v, 32'h1234_ABCD);
    wr(8'h18, 32'h0F0F_F0F0); rd(8'h18, v); chk("R2 dben", v, 32'h0F0F_F0F0);
    wr(8'h1C, 32'h8000_0001); rd(8'h1C, v); chk("R2 od", v, 32'h8000_0001);
    wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
  endtask

  task automatic t_thr;
    logic [31:0] v;
    wr(8'h80, 32'hDEAD_BEEF); rd(8'h80, v); chk("R3 thr0 low16", v, 32'h0000_BEEF);
    wr(8'hFC, 32'h1234_5678); rd(8'hFC, v); chk("R3 thr31 low16", v, 32'h0000_5678);
    rd(8'h80, v); chk("R3 thr0 kept", v, 32'h0000_BEEF);
    wr(8'h8C, 32'h0000_0004); rd(8'h8C, v); chk("R3 thr3", v, 32'h0000_0004);
  endtask

  task automatic t_pushpull;
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h0000_FFFF);
    wr(8'h0C, 32'h00FF_00F0);
    idle(2);
    chk("R4 pp oe", pad_oe, 32'h0000_FFFF);
    chk("R4 pp out", pad_out, 32'h00FF_00F0);
  endtask

  task automatic t_opendrain;
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_00F0);
    idle(2);
    chk("R5 od oe", pad_oe, 32'h0000_FF0F);
    chk("R5 od out", pad_out, 32'h0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_bypass;
    logic [31:0] v;
    wr(8'h18, 32'h0);
    pad_in = 32'h1234_5678;
    idle(4);
    rd(8'h04, v); chk("R7 bypass status", v, 32'h1234_5678);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R6 status write ignored", v, 32'h1234_5678);
    rd(8'h00, v); chk("R6 dir untouched", v, 32'h0000_FFFF);
  endtask

  task automatic t_debounce;
    logic [31:0] v;
    pad_in = 32'h0;
    idle(4);
    wr(8'h8C, 32'h4);
    wr(8'h18, 32'h0000_0008);
    pad_in = 32'h0000_0008;
    idle(20);
    rd(8'h04, v); chk("R8 not before threshold", v & 32'h8, 32'h0);
    idle(40);
    rd(8'h04, v); chk("R8 after threshold", v & 32'h8, 32'h8);
  endtask

  task automatic t_bounce;
    logic [31:0] v;
    pad_in = 32'h0;
    idle(60);
    rd(8'h04, v); chk("R8 filtered fall", v & 32'h8, 32'h0);
    pad_in = 32'h8; idle(20);
    pad_in = 32'h0; idle(6);
    pad_in = 32'h8; idle(18);
    rd(8'h04, v); chk("R9 bounce restarts count", v & 32'h8, 32'h0);
    idle(40);
    rd(8'h04, v); chk("R9 settles after hold", v & 32'h8, 32'h8);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h08, v); chk("R10 read 0x08", v, 32'h0);
    rd(8'h20, v); chk("R10 read 0x20", v, 32'h0);
    rd(8'h01, v); chk("R10 misaligned read", v, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h1D, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R10 dir untouched", v, 32'h0000_FFFF);
    rd(8'h1C, v); chk("R10 od untouched", v, 32'h0);
    rd(8'h80, v); chk("R10 thr0 untouched", v, 32'h0000_BEEF);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_thr();
    t_pushpull();
    t_opendrain();
    t_bypass();
    t_debounce();
    t_bounce();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule